// File: doc/BRIEF.md
# Raw IR Edge-Interval Timer

This block timestamps transitions of an infrared receiver line so that software can decode any remote-control protocol on its own. A programmable prescaler turns the system clock into a slower tick. A 13-bit counter counts those ticks from the most recent qualifying transition. When the next qualifying transition arrives, the block latches the elapsed tick count together with the line level that the transition produced. It then raises a one-cycle interrupt and restarts the count from zero.

The transitions that count as qualifying are chosen by a 2-bit edge-select code. The code can pick both edges, falling edges only or rising edges only. A fourth code is reserved for a hardware protocol decoder that is not part of this block, and it produces no captures. The line is resynchronised to the clock before edge detection. Software reads the latched interval and level after each interrupt. A typical setup programs the divider for a 10 µs tick and selects both edges.

Top module: `ir_edge_capture`

## Requirements
- R1: After reset, `duration`, `pulseLevel`, `busy` and `irq` are all 0.
- R2: The line passes through a two-flop synchroniser. A change on `irIn` applied between clock edges shows on `irq` at the third rising clock edge after the change, and not earlier.
- R3: One tick lasts `tickDiv`+1 clock cycles, so a field value of 9 gives a 10-cycle tick. If two captures are M clock cycles apart, the second reports `duration` = floor((M-1)/(`tickDiv`+1)).
- R4: The interval counter saturates at 8191 (all thirteen bits set) and does not wrap.
- R5: Edge select: code 1 captures on both edges, code 2 captures on falling edges only, and code 3 captures on rising edges only. A transition the code does not select raises no `irq` and leaves `duration` unchanged. It does not restart the count.
- R6: With edge select code 0, no transition causes a capture.
- R7: At each capture, `pulseLevel` takes the synchronised line level after the edge: 1 after a rising edge and 0 after a falling edge.
- R8: Each capture raises `irq` for exactly one clock cycle, and `irq` is only high while `busy` is high.
- R9: `busy` goes high at the first capture after enable or soft reset. That first capture reports `duration` 0. `busy` drops one cycle after `enable` falls.
- R10: While `softReset` is high, the block clears `duration`, `pulseLevel`, `busy`, `irq` and the counter, and it ignores transitions.
- R11: While `enable` is low, transitions cause no capture and `duration` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irIn | input | 1 | Raw IR receiver line, asynchronous |
| enable | input | 1 | Capture enable |
| softReset | input | 1 | Synchronous clear, active high |
| tickDiv | input | 12 | Tick length minus one, in clock cycles |
| edgeSel | input | 2 | 0 decoder (no capture), 1 both, 2 falling, 3 rising |
| duration | output | 13 | Latched interval in ticks |
| pulseLevel | output | 1 | Line level latched at the capture |
| busy | output | 1 | Counter running since the first capture |
| irq | output | 1 | One-cycle capture strobe |

## Verification
The bench drives alternating edges at several spacings with a divider of 0, and then with dividers of 3 and 9. This separates a correct tick period and floor rounding from off-by-one errors in the synchroniser or prescaler. The bench holds the line still for longer than 8191 ticks to expose wrapping against saturation. It then runs each edge-select code against both edge directions. Ignored edges must leave the interval intact and must not restart the count. Finally, disable and soft-reset sequences show that the first capture afterwards reports zero and that edges applied in the meantime leave no trace.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

  typedef enum logic [1:0] {
    SEL_DECODER = 2'd0,
    SEL_BOTH    = 2'd1,
    SEL_FALL    = 2'd2,
    SEL_RISE    = 2'd3
  } edgeSel_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic capture;  // qualifying edge seen this cycle
    logic tick;     // prescaler period elapsed
    logic clear;    // soft reset
    logic stop;     // capture disabled
    logic level;    // synchronised line level
  } capStrobe_t;

endpackage

// File: rtl/ir_cap_ctrl.sv
module ir_cap_ctrl
  import ir_cap_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irIn,
  input  logic             enable,
  input  logic             softReset,
  input  logic [DIV_W-1:0] tickDiv,
  input  logic [1:0]       edgeSel,
  output capStrobe_t       strobe
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic                   lineLvl;
  logic                   riseEdge;
  logic                   fallEdge;
  logic                   qualify;
  logic                   active;
  logic                   tickNow;
  logic [DIV_W-1:0]       divCnt;

  // Synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= irIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign lineLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= lineLvl;
  end

  assign riseEdge = lineLvl & ~prevLvl;
  assign fallEdge = ~lineLvl & prevLvl;
  assign active   = enable & ~softReset;

  always_comb begin
    unique case (edgeSel_e'(edgeSel))
      SEL_BOTH: qualify = riseEdge | fallEdge;
      SEL_FALL: qualify = fallEdge;
      SEL_RISE: qualify = riseEdge;
      default:  qualify = 1'b0;
    endcase
  end

  // Tick prescaler, realigned on every capture
  assign tickNow = (divCnt >= tickDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  divCnt <= '0;
    else if (!active || (qualify) || tickNow)   divCnt <= '0;
    else                                        divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobe.capture = qualify & active;
    strobe.tick    = tickNow & active;
    strobe.clear   = softReset;
    strobe.stop    = ~enable;
    strobe.level   = lineLvl;
  end

endmodule

// File: rtl/ir_cap_datapath.sv
module ir_cap_datapath
  import ir_cap_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strobe,
  output logic [CNT_W-1:0] duration,
  output logic             pulseLevel,
  output logic             busy,
  output logic             irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      duration   <= '0;
      pulseLevel <= 1'b0;
      busy       <= 1'b0;
      irq        <= 1'b0;
    end else if (strobe.clear) begin
      count      <= '0;
      duration   <= '0;
      pulseLevel <= 1'b0;
      busy       <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= strobe.capture;
      if (strobe.stop) begin
        busy  <= 1'b0;
        count <= '0;
      end else if (strobe.capture) begin
        duration   <= count;
        pulseLevel <= strobe.level;
        count      <= '0;
        busy       <= 1'b1;
      end else if (strobe.tick && busy && (count != CNT_MAX)) begin
        count <= count + 1'b1;
      end
    end
  end

  // Saturated counter stays put until restarted
  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && count == CNT_MAX && !strobe.capture && !strobe.clear && !strobe.stop)
      |=> count == CNT_MAX);

  assert_irq_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> busy);

  // Without a capture the latched interval does not move
  assert_dur_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !strobe.clear) |=> $stable(duration));

endmodule

// File: rtl/ir_edge_capture.sv
module ir_edge_capture
  import ir_cap_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int CNT_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irIn,
  input  logic             enable,
  input  logic             softReset,
  input  logic [DIV_W-1:0] tickDiv,
  input  logic [1:0]       edgeSel,
  output logic [CNT_W-1:0] duration,
  output logic             pulseLevel,
  output logic             busy,
  output logic             irq
);

  capStrobe_t strobe;

  ir_cap_ctrl #(
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irIn     (irIn),
    .enable   (enable),
    .softReset(softReset),
    .tickDiv  (tickDiv),
    .edgeSel  (edgeSel),
    .strobe   (strobe)
  );

  ir_cap_datapath #(
    .CNT_W(CNT_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .duration  (duration),
    .pulseLevel(pulseLevel),
    .busy      (busy),
    .irq       (irq)
  );

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (!irq && !busy && duration == '0 && !pulseLevel));

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !irq);

  assert_decoder_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSel == 2'd0) |=> !irq);

endmodule

// File: tb/test_ir_edge_capture.sv
module test_ir_edge_capture;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irIn = 1'b0;
  logic        enable = 1'b0;
  logic        softReset = 1'b0;
  logic [11:0] tickDiv = '0;
  logic [1:0]  edgeSel = 2'd1;
  logic [12:0] duration;
  logic        pulseLevel;
  logic        busy;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int since = 0;
  bit busyModel = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ir_edge_capture i_ir_edge_capture (
    .clk(clk), .rstN(rstN), .irIn(irIn), .enable(enable),
    .softReset(softReset), .tickDiv(tickDiv), .edgeSel(edgeSel),
    .duration(duration), .pulseLevel(pulseLevel), .busy(busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    since += n;
  endtask

  // Qualifying edge: checks timing, interval, level, busy and strobe width
  task automatic edgeCap(input logic lvl, input bit checkDur);
    int expDur;
    expDur = busyModel ? (since - 1) / (int'(tickDiv) + 1) : 0;
    if (expDur > 8191) expDur = 8191;
    irIn  = lvl;
    since = 0;
    step(2);
    chk(irq == 1'b0, "R2 irq early", int'(irq), 0);
    step(1);
    chk(irq == 1'b1, "R2 irq on third edge", int'(irq), 1);
    if (checkDur) chk(duration == 13'(expDur), "R3 duration", int'(duration), expDur);
    chk(pulseLevel == lvl, "R7 pulse level", int'(pulseLevel), int'(lvl));
    chk(busy == 1'b1, "R9 busy after capture", int'(busy), 1);
    busyModel = 1;
    step(1);
    chk(irq == 1'b0, "R8 irq single cycle", int'(irq), 0);
  endtask

  // Edge that must leave no trace
  task automatic edgeIgnored(input logic lvl, input string tag);
    logic [12:0] held;
    bit sawIrq;
    held = duration;
    sawIrq = 0;
    irIn = lvl;
    for (int i = 0; i < 4; i++) begin
      step(1);
      if (irq) sawIrq = 1;
    end
    chk(!sawIrq, {tag, " no irq"}, int'(sawIrq), 0);
    chk(duration == held, {tag, " duration held"}, int'(duration), int'(held));
  endtask

  task automatic testReset();
    step(3);
    chk(duration == 0 && !pulseLevel && !busy && !irq, "R1 reset state",
        int'({duration, pulseLevel, busy, irq}), 0);
    rstN = 1'b1;
    step(2);
    chk(duration == 0 && !busy && !irq, "R1 after release",
        int'({duration, busy, irq}), 0);
  endtask

  task automatic testBothEdges();
    tickDiv = 12'd0;
    edgeSel = 2'd1;
    enable  = 1'b1;
    step(2);
    edgeCap(1'b1, 1'b1);  // R9 first capture reports 0
    step(20);
    edgeCap(1'b0, 1'b1);
    step(7);
    edgeCap(1'b1, 1'b1);
  endtask

  task automatic testDivider();
    tickDiv = 12'd3;
    edgeCap(~irIn, 1'b0);  // realign prescaler
    step(37);
    edgeCap(~irIn, 1'b1);  // R3 exact multiple
    step(38);
    edgeCap(~irIn, 1'b1);  // R3 floor
    tickDiv = 12'd9;
    edgeCap(~irIn, 1'b0);
    step(120);
    edgeCap(~irIn, 1'b1);
  endtask

  task automatic testSaturate();
    tickDiv = 12'd0;
    edgeCap(~irIn, 1'b0);
    step(9000);
    edgeCap(~irIn, 1'b1);  // R4 expects 8191
    chk(duration == 13'h1fff, "R4 saturated", int'(duration), 8191);
  endtask

  task automatic testFallOnly();
    edgeSel = 2'd2;
    if (irIn == 1'b0) edgeIgnored(1'b1, "R5 rise ignored in fall mode");
    edgeCap(1'b0, 1'b1);
    step(3);
    edgeIgnored(1'b1, "R5 rise ignored in fall mode");
    step(5);
    edgeCap(1'b0, 1'b1);  // interval spans the ignored edge
  endtask

  task automatic testRiseOnly();
    edgeSel = 2'd3;
    if (irIn == 1'b1) edgeIgnored(1'b0, "R5 fall ignored in rise mode");
    edgeCap(1'b1, 1'b1);
    edgeIgnored(1'b0, "R5 fall ignored in rise mode");
    step(6);
    edgeCap(1'b1, 1'b1);
  endtask

  task automatic testDecoderMode();
    edgeSel = 2'd0;
    edgeIgnored(~irIn, "R6 decoder code");
    edgeIgnored(~irIn, "R6 decoder code");
    edgeSel = 2'd1;
    step(3);
    edgeCap(~irIn, 1'b1);
  endtask

  task automatic testDisable();
    logic [12:0] held;
    held = duration;
    enable = 1'b0;
    step(1);
    chk(busy == 1'b0, "R9 busy drops on disable", int'(busy), 0);
    edgeIgnored(~irIn, "R11 disabled");
    chk(duration == held, "R11 duration held", int'(duration), int'(held));
    enable = 1'b1;
    busyModel = 0;
    step(10);
    edgeCap(~irIn, 1'b1);  // R9 restart reports 0
  endtask

  task automatic testSoftReset();
    step(5);
    softReset = 1'b1;
    step(1);
    chk(duration == 0 && !pulseLevel && !busy && !irq, "R10 cleared",
        int'({duration, pulseLevel, busy, irq}), 0);
    edgeIgnored(~irIn, "R10 soft reset");
    softReset = 1'b0;
    busyModel = 0;
    step(12);
    edgeCap(~irIn, 1'b1);
  endtask

  initial begin
    testReset();
    testBothEdges();
    testDivider();
    testSaturate();
    testFallOnly();
    testRiseOnly();
    testDecoderMode();
    testDisable();
    testSoftReset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule